// File: doc/BRIEF.md
# SD Card Command and Response Engine

This block is the command half of an SD host: a small register set plus a serial engine. Software first writes a 6-bit command index and two 16-bit argument halves. It then writes an attribute word, and that write starts the command. The engine builds a 48-bit command frame with its CRC7 and shifts it out on the command line. If the attribute bit asks for it, a run of ones for card wake-up goes out before the frame. The engine then waits for the card's reply, which is either a 48-bit short frame or a 136-bit long frame.

When the reply has arrived, or when the wait has run out, the engine writes a status word and raises a one-cycle end-of-command pulse. Software then reads the reply as a series of 16-bit words through a single pop port, most significant word first. The data lines, clock division and DMA are handled elsewhere. The command line here advances one bit per clock, so the clock enable is expected to come from outside.

Top module: `sdc_cmd_engine`

## Requirements
- R1: A command goes out MSB first, one bit per clock, with `cmd_oe` high. The frame is start 0, transmission 1, index[5:0], argument[31:0], CRC7, end 1. The argument is {high register, low register}. The CRC7 uses polynomial x^7+x^3+1, starts from zero and covers the first 40 frame bits. `cmd_oe` is low whenever the engine is idle.
- R2: If attribute bit 6 is set, `INIT_CYCLES` ones (default 80) are driven with `cmd_oe` high just before the start bit. If the bit is clear, no preamble is sent.
- R3: Attribute bits [1:0] set the response kind: 0 none, 1 short with CRC check, 2 long, 3 short without CRC check. With kind 0, or with command index 0, the engine expects no reply. It finishes right after the end bit with status 0x2000.
- R4: A short reply is 48 bits long. It reads back as 3 words, frame bits [47:32], [31:16] and [15:0], so the 32-bit payload (frame bits 39:8) spans those words.
- R5: A long reply is 136 bits long. It reads back as 9 words, which are the frame followed by 8 zero bits, split into 16-bit words MSB first.
- R6: Status bit 5 is set in two cases. The first is a missing end bit. The second is a CRC mismatch: for kind 1 this is CRC7 over frame bits [47:8] against bits [7:1], and for kind 2 it is CRC7 over frame bits [127:8] against bits [7:1]. Kind 3 skips the CRC check.
- R7: A start bit (line low) must arrive within `RSP_TIMEOUT` clocks (default 64) after the end bit has been sent. If it does not, status becomes 0x2002. Status bits 0, 2, 3 and 4 stay zero.
- R8: Starting a command clears the status word and sets the pop pointer back to the first word. After reset, and after the last valid word has been popped, `rsp_word` reads zero.
- R9: While a command is in progress, register writes are ignored, including a write to the attribute register. Pops are also ignored during a command.
- R10: At completion, status bit 13 is set and `cmd_end` is high for exactly one clock.

Register addresses on `wr_addr`: 0 index, 1 argument high, 2 argument low, 3 attribute (this write starts the command).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the command bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| rsp_pop | input | 1 | Advance to the next reply word |
| rsp_word | output | 16 | Current reply word |
| status | output | 16 | Bit 13 end of command; bits 5:0 errors |
| cmd_end | output | 1 | One-cycle completion pulse |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line sampled value |

## Verification
The bench plays the card. It checks every command bit and CRC, counts the preamble ones, and answers with frames it builds from the requirements.

Several cases target specific faults:
- Replies with a flipped CRC, with an end bit of zero, and of the no-check kind separate a checker that tests the wrong field span from one that applies the check to every kind.
- Index 0 with a short kind set catches an engine that waits and then reports a timeout.
- A silent card catches a missing timeout.
- Writes issued while a command is running catch an engine that accepts them, because the next command would then carry the wrong index or start a second time.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
   localparam int CMD_BITS    = 48;
   localparam int SHORT_BITS  = 48;
   localparam int LONG_BITS   = 136;
   localparam int WORD_BITS   = 16;
   localparam int SHORT_WORDS = 3;
   localparam int LONG_WORDS  = 9;
   localparam int BUF_BITS    = LONG_WORDS * WORD_BITS;
   localparam int ST_END      = 13;
   localparam int ST_RSP_CRC  = 5;
   localparam int ST_RSP_TO   = 1;

   typedef enum logic [1:0] {
      RK_NONE  = 2'd0,
      RK_SHORT = 2'd1,
      RK_LONG  = 2'd2,
      RK_NOCRC = 2'd3
   } rsp_kind_t;

   // serial CRC7 (x^7+x^3+1) over d[n-1:0], MSB first, zero seed
   function automatic logic [6:0] sdc_crc7(input logic [127:0] d, input int n);
      logic [6:0] c;
      logic       fb;
      c = '0;
      for (int i = 127; i >= 0; i--) begin
         if (i < n) begin
            fb = d[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
         end
      end
      return c;
   endfunction
endpackage

// File: rtl/sdc_cmd_tx.sv
`timescale 1ns/1ps
module sdc_cmd_tx import sdc_pkg::*; #(
   parameter int INIT_CYCLES = 80
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                pre_en,
   input  logic [CMD_BITS-1:0] frame_i,
   output logic                cmd_out,
   output logic                cmd_oe,
   output logic                done_o
);
   localparam int PRE_W = $clog2(INIT_CYCLES + 1);
   localparam int BIT_W = $clog2(CMD_BITS + 1);
   localparam logic [PRE_W-1:0] PRE_LOAD = PRE_W'(INIT_CYCLES);
   localparam logic [BIT_W-1:0] BIT_LOAD = BIT_W'(CMD_BITS);

   generate
      if (INIT_CYCLES < 1) begin : g_bad_pre
         $error("sdc_cmd_tx: INIT_CYCLES must be at least 1");
      end
   endgenerate

   logic [CMD_BITS-1:0] sh_q;
   logic [PRE_W-1:0]    pre_left_q;
   logic [BIT_W-1:0]    bits_left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q        <= '0;
         pre_left_q  <= '0;
         bits_left_q <= '0;
         done_o      <= 1'b0;
      end else begin
         done_o <= (pre_left_q == '0) && (bits_left_q == BIT_W'(1));
         if (start) begin
            sh_q        <= frame_i;
            pre_left_q  <= pre_en ? PRE_LOAD : '0;
            bits_left_q <= BIT_LOAD;
         end else if (pre_left_q != '0) begin
            pre_left_q <= pre_left_q - PRE_W'(1);
         end else if (bits_left_q != '0) begin
            sh_q        <= {sh_q[CMD_BITS-2:0], 1'b0};
            bits_left_q <= bits_left_q - BIT_W'(1);
         end
      end
   end

   assign cmd_oe  = (pre_left_q != '0) || (bits_left_q != '0);
   assign cmd_out = (pre_left_q != '0) ? 1'b1 : sh_q[CMD_BITS-1];

   // the cycle before completion always carried a driven end bit of 1
   assert_end_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(cmd_oe && cmd_out));
endmodule

// File: rtl/sdc_rsp_rx.sv
`timescale 1ns/1ps
module sdc_rsp_rx import sdc_pkg::*; #(
   parameter int RSP_TIMEOUT = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arm,
   input  logic                 long_i,
   input  logic                 cmd_in,
   output logic                 done_o,
   output logic                 timeout_o,
   output logic [LONG_BITS-1:0] frame_o
);
   localparam int TO_W  = $clog2(RSP_TIMEOUT + 1);
   localparam int CNT_W = $clog2(LONG_BITS + 1);
   localparam logic [TO_W-1:0]  TO_LAST    = TO_W'(RSP_TIMEOUT - 1);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_BITS - 1);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_BITS - 1);

   generate
      if (RSP_TIMEOUT < 2) begin : g_bad_to
         $error("sdc_rsp_rx: RSP_TIMEOUT must be at least 2");
      end
   endgenerate

   typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_RECV} rx_state_t;
   rx_state_t        st_q;
   logic [TO_W-1:0]  wait_q;
   logic [CNT_W-1:0] got_q;
   logic             long_q;
   logic [LONG_BITS-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= RX_IDLE;
         wait_q    <= '0;
         got_q     <= '0;
         long_q    <= 1'b0;
         sh_q      <= '0;
         done_o    <= 1'b0;
         timeout_o <= 1'b0;
      end else begin
         done_o    <= 1'b0;
         timeout_o <= 1'b0;
         unique case (st_q)
            RX_IDLE: begin
               if (arm) begin
                  st_q   <= RX_WAIT;
                  wait_q <= '0;
                  long_q <= long_i;
                  sh_q   <= '0;
               end
            end
            RX_WAIT: begin
               if (!cmd_in) begin
                  sh_q  <= {sh_q[LONG_BITS-2:0], 1'b0};
                  got_q <= CNT_W'(1);
                  st_q  <= RX_RECV;
               end else if (wait_q == TO_LAST) begin
                  timeout_o <= 1'b1;
                  st_q      <= RX_IDLE;
               end else begin
                  wait_q <= wait_q + TO_W'(1);
               end
            end
            RX_RECV: begin
               sh_q <= {sh_q[LONG_BITS-2:0], cmd_in};
               if (got_q == (long_q ? LAST_LONG : LAST_SHORT)) begin
                  done_o <= 1'b1;
                  st_q   <= RX_IDLE;
               end else begin
                  got_q <= got_q + CNT_W'(1);
               end
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   assign frame_o = sh_q;

   assert_to_line_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> $past(cmd_in));
   assert_single_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, timeout_o}));
endmodule

// File: rtl/sdc_cmd_engine.sv
`timescale 1ns/1ps
module sdc_cmd_engine import sdc_pkg::*; #(
   parameter int INIT_CYCLES = 80,
   parameter int RSP_TIMEOUT = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [15:0] wr_data,
   input  logic        rsp_pop,
   output logic [15:0] rsp_word,
   output logic [15:0] status,
   output logic        cmd_end,
   output logic        cmd_out,
   output logic        cmd_oe,
   input  logic        cmd_in
);
   localparam int PTR_W = $clog2(LONG_WORDS + 1);
   localparam logic [PTR_W-1:0] NW_SHORT = PTR_W'(SHORT_WORDS);
   localparam logic [PTR_W-1:0] NW_LONG  = PTR_W'(LONG_WORDS);

   generate
      if (BUF_BITS < LONG_BITS) begin : g_bad_buf
         $error("sdc_cmd_engine: reply buffer narrower than long frame");
      end
   endgenerate

   typedef enum logic [1:0] {E_IDLE, E_SEND, E_RECV} eng_state_t;
   eng_state_t      st_q;
   logic [5:0]      idx_q;
   logic [15:0]     argh_q, argl_q;
   rsp_kind_t       kind_q;
   logic [PTR_W-1:0] ptr_q, nwords_q;
   logic [BUF_BITS-1:0] rsp_q;
   logic [15:0]     status_q;
   logic            end_q;

   wire idle   = (st_q == E_IDLE);
   wire wr_ok  = wr_en && idle;
   wire launch = wr_ok && (wr_addr == 2'd3);
   rsp_kind_t launch_kind;
   assign launch_kind = (idx_q == 6'd0) ? RK_NONE : rsp_kind_t'(wr_data[1:0]);

   logic unused_attr_bits;
   assign unused_attr_bits = ^{wr_data[15:7], wr_data[5:2]};

   // command frame
   logic [39:0]         head;
   logic [CMD_BITS-1:0] cmd_frame;
   assign head      = {2'b01, idx_q, argh_q, argl_q};
   assign cmd_frame = {head, sdc_crc7({88'b0, head}, 40), 1'b1};

   logic tx_done;
   sdc_cmd_tx #(.INIT_CYCLES(INIT_CYCLES)) tx_i (
      .clk(clk), .rst_n(rst_n), .start(launch), .pre_en(wr_data[6]),
      .frame_i(cmd_frame), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .done_o(tx_done)
   );

   logic rx_done, rx_to;
   logic [LONG_BITS-1:0] rx_frame;
   wire rx_arm = tx_done && (st_q == E_SEND) && (kind_q != RK_NONE);
   sdc_rsp_rx #(.RSP_TIMEOUT(RSP_TIMEOUT)) rx_i (
      .clk(clk), .rst_n(rst_n), .arm(rx_arm), .long_i(kind_q == RK_LONG),
      .cmd_in(cmd_in), .done_o(rx_done), .timeout_o(rx_to), .frame_o(rx_frame)
   );

   // reply checks
   logic [6:0] crc_short, crc_long;
   logic       crc_bad, end_bad, rsp_err;
   assign crc_short = sdc_crc7({88'b0, rx_frame[47:8]}, 40);
   assign crc_long  = sdc_crc7({8'b0, rx_frame[127:8]}, 120);
   always_comb begin
      unique case (kind_q)
         RK_SHORT: crc_bad = (crc_short != rx_frame[7:1]);
         RK_LONG:  crc_bad = (crc_long  != rx_frame[7:1]);
         default:  crc_bad = 1'b0;
      endcase
   end
   assign end_bad = !rx_frame[0];
   assign rsp_err = crc_bad || end_bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= E_IDLE;
         idx_q    <= '0;
         argh_q   <= '0;
         argl_q   <= '0;
         kind_q   <= RK_NONE;
         ptr_q    <= '0;
         nwords_q <= '0;
         rsp_q    <= '0;
         status_q <= '0;
         end_q    <= 1'b0;
      end else begin
         end_q <= 1'b0;
         if (wr_ok && wr_addr == 2'd0) idx_q  <= wr_data[5:0];
         if (wr_ok && wr_addr == 2'd1) argh_q <= wr_data;
         if (wr_ok && wr_addr == 2'd2) argl_q <= wr_data;
         unique case (st_q)
            E_IDLE: begin
               if (launch) begin
                  st_q     <= E_SEND;
                  kind_q   <= launch_kind;
                  status_q <= '0;
                  ptr_q    <= '0;
                  rsp_q    <= '0;
                  nwords_q <= (launch_kind == RK_NONE) ? '0 :
                              (launch_kind == RK_LONG) ? NW_LONG : NW_SHORT;
               end else if (rsp_pop && ptr_q < nwords_q) begin
                  ptr_q <= ptr_q + PTR_W'(1);
               end
            end
            E_SEND: begin
               if (tx_done) begin
                  if (kind_q == RK_NONE) begin
                     st_q             <= E_IDLE;
                     status_q[ST_END] <= 1'b1;
                     end_q            <= 1'b1;
                  end else begin
                     st_q <= E_RECV;
                  end
               end
            end
            E_RECV: begin
               if (rx_done) begin
                  st_q                 <= E_IDLE;
                  status_q[ST_END]     <= 1'b1;
                  status_q[ST_RSP_CRC] <= rsp_err;
                  end_q                <= 1'b1;
                  rsp_q <= (kind_q == RK_LONG) ? {rx_frame, 8'b0}
                                               : {rx_frame[SHORT_BITS-1:0], 96'b0};
               end else if (rx_to) begin
                  st_q                <= E_IDLE;
                  status_q[ST_END]    <= 1'b1;
                  status_q[ST_RSP_TO] <= 1'b1;
                  end_q               <= 1'b1;
               end
            end
            default: st_q <= E_IDLE;
         endcase
      end
   end

   // reply word slices
   logic [WORD_BITS-1:0] word_a [LONG_WORDS];
   for (genvar g = 0; g < LONG_WORDS; g++) begin : g_word
      assign word_a[g] = rsp_q[BUF_BITS-1-WORD_BITS*g -: WORD_BITS];
   end
   assign rsp_word = (ptr_q < nwords_q) ? word_a[ptr_q] : '0;
   assign status   = status_q;
   assign cmd_end  = end_q;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !cmd_oe);
   assert_launch_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (status == 16'h0 && ptr_q == '0));
   assert_ptr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= nwords_q);
   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !idle) |=> ($stable(idx_q) && $stable(argh_q) && $stable(argl_q)));
   assert_end_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_end |-> status[ST_END]);
   assert_end_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_end |=> !cmd_end);
endmodule

// File: tb/sdc_cmd_engine_tb.sv
`timescale 1ns/1ps
module sdc_cmd_engine_tb_top;
   localparam int INIT_N = 80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic rsp_pop = 1'b0;
   logic cmd_in = 1'b1;
   logic [15:0] rsp_word, status;
   logic cmd_end, cmd_out, cmd_oe;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   sdc_cmd_engine dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rsp_pop(rsp_pop), .rsp_word(rsp_word), .status(status), .cmd_end(cmd_end),
      .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
   );

   function automatic logic [6:0] crc7(input logic [127:0] d, input int n);
      logic [6:0] c = '0;
      for (int i = n - 1; i >= 0; i--) begin
         logic fb;
         fb = d[i] ^ c[6];
         c  = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

   function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
      logic [39:0] h = {2'b01, idx, arg};
      return {h, crc7({88'b0, h}, 40), 1'b1};
   endfunction

   task automatic chk(input string tag, input logic [143:0] act, input logic [143:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   // card model: capture command bits, optionally answer
   task automatic card(input bit respond, input int len, input logic [135:0] rsp,
                       output logic [47:0] got, output int pre);
      int guard = 0;
      pre = 0;
      do begin
         @(negedge clk);
         if (cmd_oe && cmd_out) pre++;
         guard++;
      end while (!(cmd_oe && !cmd_out) && guard < 1000);
      got = '0;
      got[47] = cmd_out;
      for (int i = 46; i >= 0; i--) begin
         @(negedge clk);
         got[i] = cmd_out;
      end
      if (respond) begin
         repeat (4) @(negedge clk);
         for (int i = len - 1; i >= 0; i--) begin
            cmd_in = rsp[i];
            @(negedge clk);
         end
         cmd_in = 1'b1;
      end
   endtask

   task automatic wait_done(output logic [15:0] st, output logic pulse, output logic after);
      st = '0; pulse = 1'b0; after = 1'b1;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (status[13]) begin
            st = status; pulse = cmd_end;
            @(negedge clk);
            after = cmd_end;
            break;
         end
      end
   endtask

   task automatic launch(input logic [5:0] idx, input logic [31:0] arg, input logic [15:0] attr);
      reg_wr(2'd0, {10'b0, idx});
      reg_wr(2'd1, arg[31:16]);
      reg_wr(2'd2, arg[15:0]);
      reg_wr(2'd3, attr);
   endtask

   task automatic pop_words(input string tag, input int n, input logic [143:0] exp);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk(tag, {128'b0, rsp_word}, {128'b0, exp[143-16*k -: 16]});
         rsp_pop = 1'b1;
         @(negedge clk);
         rsp_pop = 1'b0;
      end
      @(negedge clk);
      chk("R8 word past end reads zero", {128'b0, rsp_word}, '0);
   endtask

   task automatic t_reset();
      chk("R8 reset status", {128'b0, status}, '0);
      chk("R1 reset line released", {143'b0, cmd_oe}, '0);
      chk("R8 reset word", {128'b0, rsp_word}, '0);
   endtask

   task automatic t_short();
      logic [47:0] got, rf; logic [39:0] r40; int pre;
      logic [15:0] st; logic p, a;
      r40 = {2'b00, 6'd17, 32'hC0FF_EE42};
      rf  = {r40, crc7({88'b0, r40}, 40), 1'b1};
      launch(6'd17, 32'h1234_5678, 16'h0001);
      card(1'b1, 48, {88'b0, rf}, got, pre);
      wait_done(st, p, a);
      chk("R1 command frame", {96'b0, got}, {96'b0, cmd_frame(6'd17, 32'h1234_5678)});
      chk("R2 no preamble when bit clear", 144'(pre), '0);
      chk("R4 short status", {128'b0, st}, {128'b0, 16'h2000});
      chk("R10 end pulse high", {143'b0, p}, {143'b0, 1'b1});
      chk("R10 end pulse one cycle", {143'b0, a}, '0);
      pop_words("R4 short word", 3, {rf, 96'b0});
   endtask

   task automatic t_preamble();
      logic [47:0] got, rf; logic [39:0] r40; int pre;
      logic [15:0] st; logic p, a;
      r40 = {2'b00, 6'h3f, 32'h00FF_8000};
      rf  = {r40, 7'h7f, 1'b1};
      launch(6'd55, 32'h0, 16'h0043);
      card(1'b1, 48, {88'b0, rf}, got, pre);
      wait_done(st, p, a);
      chk("R2 preamble length", 144'(pre), 144'(INIT_N));
      chk("R1 frame after preamble", {96'b0, got}, {96'b0, cmd_frame(6'd55, 32'h0)});
      chk("R6 no-check kind ignores crc", {128'b0, st}, {128'b0, 16'h2000});
      pop_words("R4 no-check kind word", 3, {rf, 96'b0});
   endtask

   task automatic t_long(input bit corrupt);
      logic [47:0] got; logic [135:0] rf; logic [119:0] body; int pre;
      logic [15:0] st; logic p, a;
      body = 120'h0123_4567_89ab_cdef_fedc_ba98_7654_32;
      rf = {2'b00, 6'h3f, body, crc7({8'b0, body}, 120) ^ {6'b0, corrupt}, 1'b1};
      launch(6'd2, 32'h0, 16'h0002);
      card(1'b1, 136, rf, got, pre);
      wait_done(st, p, a);
      if (!corrupt) begin
         chk("R5 long status", {128'b0, st}, {128'b0, 16'h2000});
         pop_words("R5 long word", 9, {rf, 8'b0});
      end else begin
         chk("R6 long crc mismatch", {128'b0, st}, {128'b0, 16'h2020});
      end
   endtask

   task automatic t_short_bad(input logic [15:0] attr, input bit bad_crc, input bit bad_end,
                              input logic [15:0] exp_st, input string tag);
      logic [47:0] got, rf; logic [39:0] r40; int pre;
      logic [15:0] st; logic p, a;
      r40 = {2'b00, 6'd23, 32'hA5A5_0F0F};
      rf  = {r40, crc7({88'b0, r40}, 40) ^ {6'b0, bad_crc}, !bad_end};
      launch(6'd23, 32'hDEAD_BEEF, attr);
      card(1'b1, 48, {88'b0, rf}, got, pre);
      wait_done(st, p, a);
      chk(tag, {128'b0, st}, {128'b0, exp_st});
   endtask

   task automatic t_noresp(input logic [5:0] idx, input logic [15:0] attr, input string tag);
      logic [47:0] got; int pre;
      logic [15:0] st; logic p, a;
      launch(idx, 32'h0000_01AA, attr);
      card(1'b0, 0, '0, got, pre);
      wait_done(st, p, a);
      chk(tag, {128'b0, st}, {128'b0, 16'h2000});
      chk("R3 no reply words", {128'b0, rsp_word}, '0);
   endtask

   task automatic t_timeout();
      logic [47:0] got; int pre;
      logic [15:0] st; logic p, a;
      launch(6'd13, 32'h0001_0000, 16'h0001);
      card(1'b0, 0, '0, got, pre);
      wait_done(st, p, a);
      chk("R7 timeout status", {128'b0, st}, {128'b0, 16'h2002});
   endtask

   task automatic t_busy();
      logic [47:0] got; int pre;
      logic [15:0] st; logic p, a;
      launch(6'd17, 32'h1111_2222, 16'h0001);
      repeat (3) @(negedge clk);
      reg_wr(2'd0, 16'd9);
      reg_wr(2'd2, 16'hFFFF);
      reg_wr(2'd3, 16'h0000);
      wait_done(st, p, a);
      chk("R9 attribute write ignored while busy", {128'b0, st}, {128'b0, 16'h2002});
      reg_wr(2'd3, 16'h0000);
      chk("R8 status cleared at launch", {128'b0, status}, '0);
      card(1'b0, 0, '0, got, pre);
      chk("R9 index and argument kept", {96'b0, got}, {96'b0, cmd_frame(6'd17, 32'h1111_2222)});
      wait_done(st, p, a);
      chk("R3 kind none completes", {128'b0, st}, {128'b0, 16'h2000});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short();
      t_preamble();
      t_long(1'b0);
      t_long(1'b1);
      t_short_bad(16'h0001, 1'b1, 1'b0, 16'h2020, "R6 short crc mismatch");
      t_short_bad(16'h0003, 1'b0, 1'b1, 16'h2020, "R6 missing end bit");
      t_noresp(6'd5, 16'h0000, "R3 kind none");
      t_noresp(6'd0, 16'h0001, "R3 index zero expects no reply");
      t_timeout();
      t_busy();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule